// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Controller

This block holds the replacement state of an 8-way set-associative cache. Every set stores eight valid flags and a seven-node binary decision tree. A lookup port takes a set index and returns, without any clock delay, the way that the next fill of that set should overwrite. An update port takes a set index, a way and an access kind, and changes the addressed set at the next rising clock edge.

There are four access kinds. An ordinary access (a hit or a reload) makes its way the most recently used. A demoting access (a hit or a reload) makes its way the least recently used, so the next fill evicts it unless the set is accessed again first. Reload kinds also set the valid flag of the filled way. A flash-invalidate input clears every set in one cycle. A parameter turns demotion off so the same block can serve an instruction cache. In that mode demoting kinds behave as ordinary ones.

Top module: `plru8_repl_ctrl`

## Requirements
- R1: After reset, every set has all ways invalid and all tree nodes at zero, so the lookup returns way 0 for every set.
- R2: While any way of the looked-up set is invalid, the lookup returns the lowest-numbered invalid way and ignores the tree.
- R3: When all eight ways are valid, the lookup walks the tree. Node 0 at 0 picks ways 0-3 and at 1 picks ways 4-7. In the low half, node 1 picks the pair {0,1} at 0 and the pair {2,3} at 1. In the high half, node 2 picks {4,5} at 0 and {6,7} at 1. The last choice uses node 3 for {0,1}, node 4 for {2,3}, node 5 for {4,5} and node 6 for {6,7}: a value of 0 picks the lower way of the pair and 1 picks the upper way.
- R4: An ordinary access to way w = {w2,w1,w0} writes exactly three nodes and leaves the others unchanged. Node 0 becomes ~w2. Node 1 (when w2=0) or node 2 (when w2=1) becomes ~w1. Leaf node 3+{w2,w1} becomes ~w0.
- R5: Access kinds are encoded on upd_kind: 00 ordinary hit, 01 ordinary reload, 10 demoting hit, 11 demoting reload. Bit 0 set means reload and marks the way valid at the edge. Hit kinds leave every valid flag unchanged.
- R6: A demoting access writes the complement of the three values R4 gives for the same way. With all ways valid and no further access to that set, the lookup then returns that way.
- R7: With ENABLE_DEMOTE=0, kinds 10 and 11 update the tree exactly as kinds 00 and 01.
- R8: A flash invalidate clears all valid flags and tree nodes of every set at the next edge, and it overrides an update issued in the same cycle.
- R9: An update changes only the set it addresses.
- R10: The lookup output reflects the stored state, so an update becomes visible only after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flash_inv | input | 1 | Clears the state of all sets at the next edge |
| lookup_set | input | SET_W | Set whose victim is requested |
| victim_way | output | 3 | Way to fill in lookup_set |
| upd_en | input | 1 | Update request |
| upd_set | input | SET_W | Set being updated |
| upd_way | input | 3 | Way that was accessed |
| upd_kind | input | 2 | Access kind, encoded as in R5 |

## Verification
The victim is combinational, so the bench drives lookup_set after a falling edge and samples 1 ns later, within the same cycle. Each update is presented after a falling edge. The bench first samples the victim of the updated set before the next rising edge, which must still show the old state (R10). It samples again after the following falling edge, where the new state must appear, one register stage later. A flash request is checked the same way, one edge after it is raised.

// File: rtl/plru8_pkg.sv
package plru8_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = 3;
    localparam int TREE_W = WAYS - 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAYS-1:0]   vmask_t;

    typedef enum logic [1:0] {
        ACC_HIT         = 2'b00,
        ACC_RELOAD      = 2'b01,
        ACC_DEMOTE_HIT  = 2'b10,
        ACC_DEMOTE_FILL = 2'b11
    } acc_kind_e;
endpackage

// File: rtl/plru8_tree_next.sv
module plru8_tree_next
    import plru8_pkg::*;
(
    input  tree_t tree_in,
    input  way_t  way,
    input  logic  demote,
    output tree_t tree_out
);
    logic [1:0] leaf_sel;

    always_comb begin
        leaf_sel = way[2:1];
        tree_out = tree_in;
        // root points away from the accessed half (toward it when demoting)
        tree_out[0] = ~way[2] ^ demote;
        if (way[2] == 1'b0) begin
            tree_out[1] = ~way[1] ^ demote;
        end else begin
            tree_out[2] = ~way[1] ^ demote;
        end
        case (leaf_sel)
            2'd0:    tree_out[3] = ~way[0] ^ demote;
            2'd1:    tree_out[4] = ~way[0] ^ demote;
            2'd2:    tree_out[5] = ~way[0] ^ demote;
            default: tree_out[6] = ~way[0] ^ demote;
        endcase
    end
endmodule

// File: rtl/plru8_victim.sv
module plru8_victim
    import plru8_pkg::*;
(
    input  tree_t  tree,
    input  vmask_t valid,
    output way_t   victim
);
    way_t       first_free;
    logic       any_free;
    way_t       walk;
    logic       pick_hi;
    logic       pair_sel;
    logic [1:0] pair_idx;

    // lowest invalid way: scan from the top so the lowest index wins
    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                first_free = way_t'(i);
                any_free   = 1'b1;
            end
        end
    end

    always_comb begin
        pick_hi  = tree[0];
        pair_sel = pick_hi ? tree[2] : tree[1];
        pair_idx = {pick_hi, pair_sel};
        walk     = {pick_hi, pair_sel, tree[3 + int'(pair_idx)]};
        victim   = any_free ? first_free : walk;
    end
endmodule

// File: rtl/plru8_state_store.sv
module plru8_state_store
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  way_t             upd_way,
    input  logic             upd_demote,
    input  logic             upd_reload,
    input  logic [SET_W-1:0] rd_set,
    output tree_t            rd_tree,
    output vmask_t           rd_valid
);
    typedef struct packed {
        logic [NUM_SETS-1:0][TREE_W-1:0] tree;
        logic [NUM_SETS-1:0][WAYS-1:0]   valid;
    } store_t;

    store_t st_d, st_q;
    tree_t  cur_tree;
    tree_t  new_tree;
    logic   upd_in_range;
    logic   rd_in_range;

    assign upd_in_range = (int'(upd_set) < NUM_SETS);
    assign rd_in_range  = (int'(rd_set) < NUM_SETS);

    always_comb begin
        cur_tree = '0;
        if (upd_in_range) begin
            cur_tree = st_q.tree[upd_set];
        end
    end

    plru8_tree_next u_next (
        .tree_in  (cur_tree),
        .way      (upd_way),
        .demote   (upd_demote),
        .tree_out (new_tree)
    );

    always_comb begin
        st_d = st_q;
        if (flash) begin
            st_d = '0;
        end else if (upd_en && upd_in_range) begin
            st_d.tree[upd_set] = new_tree;
            if (upd_reload) begin
                st_d.valid[upd_set][upd_way] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_tree  = '0;
        rd_valid = '0;
        if (rd_in_range) begin
            rd_tree  = st_q.tree[rd_set];
            rd_valid = st_q.valid[rd_set];
        end
    end

    // R4 / R9: an update touches at most three tree nodes across all sets
    p_three_nodes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !flash) |=> ($countones(st_q.tree ^ $past(st_q.tree)) <= 3));

    // R5: the reloaded way is valid after the edge
    p_reload_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_reload && !flash && upd_in_range)
            |=> st_q.valid[$past(upd_set)][$past(upd_way)]);

    // R5: a hit never alters any valid flag
    p_hit_keeps_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash && !(upd_en && upd_reload)) |=> (st_q.valid == $past(st_q.valid)));

    // R8: flash leaves nothing set
    p_flash_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flash |=> (st_q == '0));
endmodule

// File: rtl/plru8_repl_ctrl.sv
module plru8_repl_ctrl
    import plru8_pkg::*;
#(
    parameter int NUM_SETS      = 16,
    parameter bit ENABLE_DEMOTE = 1'b1,
    parameter int SET_W         = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash_inv,
    input  logic [SET_W-1:0] lookup_set,
    output logic [2:0]       victim_way,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [2:0]       upd_way,
    input  logic [1:0]       upd_kind
);
    acc_kind_e kind;
    logic      demote_eff;
    logic      reload;
    tree_t     rd_tree;
    vmask_t    rd_valid;
    way_t      victim;

    assign kind   = acc_kind_e'(upd_kind);
    assign reload = (kind == ACC_RELOAD) || (kind == ACC_DEMOTE_FILL);

    generate
        if (ENABLE_DEMOTE) begin : g_demote
            assign demote_eff = (kind == ACC_DEMOTE_HIT) || (kind == ACC_DEMOTE_FILL);
        end else begin : g_no_demote
            assign demote_eff = 1'b0;
        end
    endgenerate

    plru8_state_store #(
        .NUM_SETS (NUM_SETS),
        .SET_W    (SET_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flash      (flash_inv),
        .upd_en     (upd_en),
        .upd_set    (upd_set),
        .upd_way    (upd_way),
        .upd_demote (demote_eff),
        .upd_reload (reload),
        .rd_set     (lookup_set),
        .rd_tree    (rd_tree),
        .rd_valid   (rd_valid)
    );

    plru8_victim u_victim (
        .tree   (rd_tree),
        .valid  (rd_valid),
        .victim (victim)
    );

    assign victim_way = victim;

    // R2: a set with a free way never offers an occupied one
    p_free_way_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(&rd_valid) |-> !rd_valid[victim_way]);

    // R8: after a flash every set offers way 0
    p_flash_victim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flash_inv |=> (victim_way == 3'd0));
endmodule

// File: tb/tb_plru8_repl_ctrl.sv
module tb_plru8_repl_ctrl;
    localparam int NS = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flash_inv = 1'b0;
    logic [SW-1:0] lookup_set = '0;
    logic [2:0]    victim_way, victim_ic;
    logic          upd_en = 1'b0;
    logic [SW-1:0] upd_set = '0;
    logic [2:0]    upd_way = '0;
    logic [1:0]    upd_kind = '0;

    int errors = 0;
    int checks = 0;

    logic [6:0] m_tree [NS];
    logic [6:0] i_tree [NS];
    logic [7:0] m_valid [NS];

    always #5 clk = ~clk;

    plru8_repl_ctrl #(.NUM_SETS(NS), .ENABLE_DEMOTE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .flash_inv(flash_inv), .lookup_set(lookup_set),
        .victim_way(victim_way), .upd_en(upd_en), .upd_set(upd_set),
        .upd_way(upd_way), .upd_kind(upd_kind));

    plru8_repl_ctrl #(.NUM_SETS(NS), .ENABLE_DEMOTE(1'b0)) dut_ic (
        .clk(clk), .rst_n(rst_n), .flash_inv(flash_inv), .lookup_set(lookup_set),
        .victim_way(victim_ic), .upd_en(upd_en), .upd_set(upd_set),
        .upd_way(upd_way), .upd_kind(upd_kind));

    function automatic logic [2:0] exp_victim(logic [6:0] t, logic [7:0] v);
        for (int i = 0; i < 8; i++) if (!v[i]) return 3'(i);
        if (!t[0]) begin
            if (!t[1]) return t[3] ? 3'd1 : 3'd0;
            else       return t[4] ? 3'd3 : 3'd2;
        end else begin
            if (!t[2]) return t[5] ? 3'd5 : 3'd4;
            else       return t[6] ? 3'd7 : 3'd6;
        end
    endfunction

    // rows of the update rule; demote inverts the written values
    function automatic logic [6:0] exp_tree(logic [6:0] t, logic [2:0] w, logic dm);
        logic [6:0] r = t;
        case (w)
            3'd0: begin r[0] = 1; r[1] = 1; r[3] = 1; end
            3'd1: begin r[0] = 1; r[1] = 1; r[3] = 0; end
            3'd2: begin r[0] = 1; r[1] = 0; r[4] = 1; end
            3'd3: begin r[0] = 1; r[1] = 0; r[4] = 0; end
            3'd4: begin r[0] = 0; r[2] = 1; r[5] = 1; end
            3'd5: begin r[0] = 0; r[2] = 1; r[5] = 0; end
            3'd6: begin r[0] = 0; r[2] = 0; r[6] = 1; end
            default: begin r[0] = 0; r[2] = 0; r[6] = 0; end
        endcase
        if (dm) begin
            r[0] = ~r[0];
            if (w[2]) r[2] = ~r[2]; else r[1] = ~r[1];
            r[3 + int'(w[2:1])] = ~r[3 + int'(w[2:1])];
        end
        return r;
    endfunction

    task automatic check_eq(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: victim actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called just after a falling edge; samples within the same cycle
    task automatic check_set(string req, int s);
        lookup_set = SW'(s);
        #1;
        check_eq(req, victim_way, exp_victim(m_tree[s], m_valid[s]));
        check_eq({req, "/R7"}, victim_ic, exp_victim(i_tree[s], m_valid[s]));
    endtask

    task automatic do_update(int s, int w, int k);
        @(negedge clk);
        upd_en = 1'b1; upd_set = SW'(s); upd_way = 3'(w); upd_kind = 2'(k);
        check_set("R10", s);
        @(negedge clk);
        upd_en = 1'b0;
        m_tree[s] = exp_tree(m_tree[s], 3'(w), k[1]);
        i_tree[s] = exp_tree(i_tree[s], 3'(w), 1'b0);
        if (k[0]) m_valid[s][w] = 1'b1;
    endtask

    task automatic clear_model();
        for (int s = 0; s < NS; s++) begin
            m_tree[s] = '0; i_tree[s] = '0; m_valid[s] = '0;
        end
    endtask

    initial begin
        #150000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        int order [8] = '{7, 3, 5, 0, 6, 1, 4, 2};
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int s = 0; s < NS; s++) check_set("R1", s);

        // R5: a hit on an invalid way leaves it free
        do_update(2, 0, 0);
        check_set("R5", 2);
        do_update(2, 5, 2);
        check_set("R5", 2);

        // R2/R5: fill set 1 in order, set 2 scrambled
        for (int w = 0; w < 8; w++) begin
            do_update(1, w, 1);
            check_set("R2", 1);
        end
        for (int i = 0; i < 8; i++) begin
            do_update(2, order[i], 1);
            check_set("R2", 2);
            check_set("R9", 1);
        end

        // R3/R4: ordinary hits on each way of a full set
        for (int w = 0; w < 8; w++) begin
            do_update(1, w, 0);
            check_set("R3", 1);
            check_set("R4", 1);
        end

        // R6: demoting hit makes the way the next victim
        for (int w = 0; w < 8; w++) begin
            do_update(1, w, 2);
            check_set("R6", 1);
        end

        // R6/R5: demoting reload into an empty set
        do_update(3, 4, 3);
        check_set("R6", 3);
        for (int w = 0; w < 8; w++) if (w != 4) do_update(3, w, 1);
        do_update(3, 6, 3);
        check_set("R6", 3);

        // R3/R4/R6/R7/R9: pseudo-random access sweep on full sets
        lfsr = 8'hA5;
        for (int i = 0; i < 300; i++) begin
            int s = lfsr[0] ? 1 : 3;
            do_update(s, int'(lfsr[3:1]), int'({lfsr[5], 1'b0}));
            check_set("R3", s);
            check_set("R9", (s == 1) ? 2 : 1);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end

        // R8: flash wins over a concurrent update
        @(negedge clk);
        flash_inv = 1'b1; upd_en = 1'b1; upd_set = 2'd1; upd_way = 3'd0; upd_kind = 2'd1;
        @(negedge clk);
        flash_inv = 1'b0; upd_en = 1'b0;
        clear_model();
        for (int s = 0; s < NS; s++) check_set("R8", s);
        do_update(1, 0, 1);
        check_set("R8", 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule